// File: doc/BRIEF.md
# Compare-Match Timer with Programmable TOP

This block is a 10-bit up-counter with a period that software sets. On each cycle that has `tick_en` high, the counter steps by one. When it reaches the value in the period register, it returns to zero on the next tick and latches a wrap flag. Three compare channels (A, B and D) each hold a value. A channel latches its own flag when the count equals that value on a tick. The same match can also toggle a waveform pin for that channel.

Each flag is sticky. Software clears a flag by pulsing the matching bit of `flag_clr`. A per-flag mask routes the flags onto one interrupt line. All settings arrive through one write port, with a select code and a data word. A write takes effect on the clock edge where it is presented.

With the period register at its reset value of 0x0FF, the block behaves as an 8-bit timer. Loading a larger period uses the full 10-bit range.

Top module: `cmp_timer`

## Requirements
- R1: After synchronous reset the outputs are as follows: `count` is 0, `flags` is 0, `irq` is 0 and `wave` is 0. Internally, the period register is 0x0FF, the compare values are 0, the mask is 0 and the toggle enables are 0.
- R2: On a clock edge with `tick_en` high, `count` rises by one unless R3 or R4 applies. With `tick_en` low, `count` holds its value.
- R3: A tick that sees `count` equal to the period register loads 0 into `count` and sets wrap flag `flags[0]`.
- R4: If `count` is above the period register, it runs up to 0x3FF. The next tick loads 0 and sets `flags[0]`.
- R5: A tick that sees `count` equal to the compare value of channel A, B or D sets `flags[1]`, `flags[2]` or `flags[3]` respectively. No flag sets on a cycle without a tick.
- R6: A flag stays set until a 1 arrives on the same bit of `flag_clr`, which clears it on that edge. If a set and a clear arrive for one flag on the same edge, the flag ends set.
- R7: `irq` is high exactly when some bit of `flags` is set and the mask bit at the same position is 1.
- R8: `wave[0]`, `wave[1]` and `wave[2]` belong to channels A, B and D. A pin inverts on each edge where its channel matches (R5) and its toggle-enable bit is 1. In every other case the pin holds.
- R9: With the period register at 0, a running counter stays at 0 and sets `flags[0]` on every tick.
- R10: With the reset period of 0x0FF, the count runs 0 to 255 and returns to 0 on the 256th tick. This is the 8-bit behaviour.
- R11: Write select codes are as follows:
  - 0: compare A.
  - 1: compare B.
  - 2: compare D.
  - 3: period.
  - 4: mask, taken from `wr_data[3:0]`.
  - 5: toggle enables, taken from `wr_data[2:0]` for A, B and D.
  
  Codes 6 and 7 change nothing. A written value governs matching from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable (one prescaled tick) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code (R11) |
| wr_data | input | 10 | Write data |
| flag_clr | input | 4 | Write-one-to-clear strobes for the flags |
| count | output | 10 | Current counter value |
| flags | output | 4 | Sticky flags: bit 0 wrap, bits 1 to 3 for channels A, B and D |
| irq | output | 1 | Masked OR of the flags |
| wave | output | 3 | Toggle-on-match pins for channels A, B and D |

## Verification
The counter is first run from reset with the default period. This confirms the 256-tick 8-bit cycle and separates a wrap at the period register from a wrap at 0x3FF. A small period with a compare value is then used to land a flag clear on the same edge as that flag's set, which shows which of the two wins.

A period of zero is loaded while the count is 0. The period is also lowered below a running count, which forces the run-out to 0x3FF. Writes with the unused select codes are followed by ticks, so that any register they corrupted would show in the later matches.

Finally, random stimulus exercises the block. It uses gated ticks, small random periods and compare values, random masks and toggle enables, and sparse clears. This mix separates errors in matching, in flag priority, in interrupt masking and in pin toggling.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    localparam int CNT_W  = 10;
    localparam int NUM_CH = 3;
    localparam int NUM_FL = NUM_CH + 1;
    localparam int SEL_W  = 3;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMP_A  = 3'd0,
        SEL_CMP_B  = 3'd1,
        SEL_CMP_D  = 3'd2,
        SEL_PERIOD = 3'd3,
        SEL_MASK   = 3'd4,
        SEL_TOGGLE = 3'd5
    } wsel_e;

    typedef struct packed {
        logic  en;
        wsel_e sel;
        cnt_t  data;
    } wreq_t;

    localparam cnt_t CNT_MAX = '1;

    function automatic logic ends_run(cnt_t cur, cnt_t period);
        return (cur == period) || (cur == CNT_MAX);
    endfunction

    function automatic logic hits(wreq_t w, wsel_e s);
        return w.en && (w.sel == s);
    endfunction
endpackage

// File: rtl/ctm_counter.sv
module ctm_counter
    import cmp_timer_pkg::*;
#(
    parameter cnt_t PERIOD_RST = cnt_t'(10'h0FF)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic period_wr,
    input  cnt_t period_data,
    output cnt_t count_q,
    output logic wrap
);
    cnt_t period_q;

    assign wrap = tick && ends_run(count_q, period_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            period_q <= PERIOD_RST;
        end else begin
            if (tick) count_q <= wrap ? '0 : count_q + 1'b1;
            if (period_wr) period_q <= period_data;
        end
    end

    assert_clear_at_period_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && count_q == period_q) |=> (count_q == '0));
    assert_wrap_at_max_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && count_q == CNT_MAX) |=> (count_q == '0));
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && count_q != period_q && count_q != CNT_MAX)
        |=> (count_q == cnt_t'($past(count_q) + 1'b1)));
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count_q));
endmodule

// File: rtl/ctm_channel.sv
module ctm_channel
    import cmp_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  cnt_t count,
    input  logic cmp_wr,
    input  cnt_t cmp_data,
    input  logic tog_en,
    output logic match,
    output logic wave_q
);
    cnt_t cmp_q;

    assign match = tick && (count == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            wave_q <= 1'b0;
        end else begin
            if (cmp_wr) cmp_q <= cmp_data;
            if (match && tog_en) wave_q <= ~wave_q;
        end
    end

    assert_toggle_R8: assert property (@(posedge clk) disable iff (rst)
        (match && tog_en) |=> (wave_q != $past(wave_q)));
    assert_pin_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !(match && tog_en) |=> $stable(wave_q));
    assert_no_match_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !tick |-> !match);
endmodule

// File: rtl/ctm_flags.sv
module ctm_flags
    import cmp_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_FL-1:0] set_i,
    input  logic [NUM_FL-1:0] clr_i,
    input  logic [NUM_FL-1:0] mask_i,
    output logic [NUM_FL-1:0] flags_q,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= set_i | (flags_q & ~clr_i);
    end

    assign irq = |(flags_q & mask_i);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & ~set_i) != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_i == '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter logic [9:0] PERIOD_RST = 10'h0FF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [9:0]  wr_data,
    input  logic [3:0]  flag_clr,
    output logic [9:0]  count,
    output logic [3:0]  flags,
    output logic        irq,
    output logic [2:0]  wave
);
    wreq_t             req;
    logic [NUM_FL-1:0] mask_q;
    logic [NUM_CH-1:0] tog_q;
    logic [NUM_CH-1:0] match;
    logic              wrap;
    cnt_t              cnt;

    assign req = '{en: wr_en, sel: wsel_e'(wr_sel), data: wr_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            tog_q  <= '0;
        end else begin
            if (hits(req, SEL_MASK))   mask_q <= req.data[NUM_FL-1:0];
            if (hits(req, SEL_TOGGLE)) tog_q  <= req.data[NUM_CH-1:0];
        end
    end

    ctm_counter #(.PERIOD_RST(cnt_t'(PERIOD_RST))) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_en),
        .period_wr   (hits(req, SEL_PERIOD)),
        .period_data (req.data),
        .count_q     (cnt),
        .wrap        (wrap)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ctm_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick_en),
            .count    (cnt),
            .cmp_wr   (req.en && (req.sel == wsel_e'(c))),
            .cmp_data (req.data),
            .tog_en   (tog_q[c]),
            .match    (match[c]),
            .wave_q   (wave[c])
        );
    end

    ctm_flags u_fl (
        .clk     (clk),
        .rst     (rst),
        .set_i   ({match, wrap}),
        .clr_i   (flag_clr),
        .mask_i  (mask_q),
        .flags_q (flags),
        .irq     (irq)
    );

    assign count = cnt;

    assert_count_zero_after_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count == '0 && flags[0]));
    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));
endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [9:0] wr_data = '0;
    logic [3:0] flag_clr = '0;
    logic [9:0] count;
    logic [3:0] flags;
    logic       irq;
    logic [2:0] wave;

    int vectors = 0;
    int errors  = 0;

    logic [9:0] m_count, m_top;
    logic [9:0] m_cmp [3];
    logic [3:0] m_mask, m_flags;
    logic [2:0] m_ten, m_wave;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .flag_clr(flag_clr), .count(count), .flags(flags),
        .irq(irq), .wave(wave)
    );

    function automatic logic [3:0] exp_sets(logic en);
        logic [3:0] s;
        s[0] = en && (m_count == m_top || m_count == 10'h3FF);
        for (int i = 0; i < 3; i++) s[i+1] = en && (m_count == m_cmp[i]);
        return s;
    endfunction

    function automatic logic [9:0] exp_next_count(logic en);
        if (!en) return m_count;
        if (m_count == m_top || m_count == 10'h3FF) return 10'd0;
        return m_count + 10'd1;
    endfunction

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_count = '0; m_top = 10'h0FF; m_mask = '0; m_flags = '0;
        m_ten = '0; m_wave = '0;
        for (int i = 0; i < 3; i++) m_cmp[i] = '0;
    endtask

    task automatic apply(logic en, logic we, logic [2:0] sel, logic [9:0] data,
                         logic [3:0] clr, string rc, string rf);
        logic [3:0] s;
        tick_en = en; wr_en = we; wr_sel = sel; wr_data = data; flag_clr = clr;
        s = exp_sets(en);
        m_wave  = m_wave ^ (s[3:1] & m_ten);
        m_flags = s | (m_flags & ~clr);
        m_count = exp_next_count(en);
        if (we) begin
            case (sel)
                3'd0, 3'd1, 3'd2: m_cmp[sel] = data;
                3'd3: m_top = data;
                3'd4: m_mask = data[3:0];
                3'd5: m_ten = data[2:0];
                default: ;
            endcase
        end
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0; flag_clr = '0;
        chk(rc, "count", 32'(count), 32'(m_count));
        chk(rf, "flags", 32'(flags), 32'(m_flags));
        chk("R7", "irq", 32'(irq), 32'(|(m_flags & m_mask)));
        chk("R8", "wave", 32'(wave), 32'(m_wave));
    endtask

    task automatic tick_to(logic [9:0] target, string rq);
        while (m_count != target) apply(1'b1, 1'b0, 3'd0, 10'd0, 4'd0, rq, rq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "count", 32'(count), 0);
        chk("R1", "flags", 32'(flags), 0);
        chk("R1", "irq", 32'(irq), 0);
        chk("R1", "wave", 32'(wave), 0);

        // R10: default period gives 256-tick run
        tick_to(10'd255, "R10");
        chk("R10", "no wrap yet", 32'(flags[0]), 0);
        apply(1'b1, 1'b0, 3'd0, 10'd0, 4'd0, "R10", "R10");
        chk("R10", "count after 256 ticks", 32'(count), 0);
        chk("R10", "wrap flag", 32'(flags[0]), 1);
        apply(1'b0, 1'b0, 3'd0, 10'd0, 4'hF, "R6", "R6");
        chk("R6", "flags cleared", 32'(flags), 0);

        // R3 and R6: small period, clear collides with set
        apply(1'b0, 1'b1, 3'd3, 10'd3, 4'd0, "R11", "R11");
        apply(1'b0, 1'b1, 3'd0, 10'd2, 4'd0, "R11", "R11");
        apply(1'b0, 1'b1, 3'd5, 10'd1, 4'd0, "R11", "R11");
        tick_to(10'd2, "R3");
        apply(1'b1, 1'b0, 3'd0, 10'd0, 4'b0010, "R3", "R6");
        chk("R6", "set beats clear", 32'(flags[1]), 1);
        apply(1'b0, 1'b0, 3'd0, 10'd0, 4'b0010, "R6", "R6");
        chk("R6", "clear alone", 32'(flags[1]), 0);
        apply(1'b1, 1'b0, 3'd0, 10'd0, 4'd0, "R3", "R3");
        chk("R3", "count at period clears", 32'(count), 0);
        chk("R3", "wrap flag", 32'(flags[0]), 1);

        // R11: unused select codes change nothing
        apply(1'b0, 1'b1, 3'd6, 10'd1, 4'd0, "R11", "R11");
        apply(1'b0, 1'b1, 3'd7, 10'd0, 4'd0, "R11", "R11");
        for (int k = 0; k < 12; k++) apply(1'b1, 1'b0, 3'd0, 10'd0, 4'hF, "R11", "R11");

        // R9: period 0 loaded while count wraps to 0
        tick_to(10'd3, "R9");
        apply(1'b1, 1'b1, 3'd3, 10'd0, 4'hF, "R9", "R9");
        for (int k = 0; k < 5; k++) begin
            apply(1'b1, 1'b0, 3'd0, 10'd0, 4'b0001, "R9", "R9");
            chk("R9", "count stays 0", 32'(count), 0);
            chk("R9", "wrap every tick", 32'(flags[0]), 1);
        end

        // R4: period lowered below a running count
        apply(1'b0, 1'b1, 3'd3, 10'd255, 4'hF, "R4", "R4");
        tick_to(10'd20, "R4");
        apply(1'b1, 1'b1, 3'd3, 10'd10, 4'hF, "R4", "R4");
        tick_to(10'h3FF, "R4");
        chk("R4", "no wrap before max", 32'(flags[0]), 0);
        apply(1'b1, 1'b0, 3'd0, 10'd0, 4'd0, "R4", "R4");
        chk("R4", "count after max", 32'(count), 0);
        chk("R4", "wrap at max", 32'(flags[0]), 1);

        // Random phase
        for (int k = 0; k < 3000; k++) begin
            logic       en, we;
            logic [2:0] sel;
            logic [9:0] data;
            logic [3:0] clr;
            en   = ($urandom % 4) != 0;
            we   = ($urandom % 12) == 0;
            sel  = 3'($urandom % 8);
            data = 10'($urandom % 40);
            clr  = (($urandom % 8) == 0) ? 4'($urandom) : 4'd0;
            apply(en, we, sel, data, clr, "R2", "R5");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule